// File: doc/BRIEF.md
# Speculative Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A table of two-bit saturating counters is indexed by the global history register XORed with a slice of the branch address. Branches are resolved many cycles after they are fetched. For that reason the history used for lookups (the speculative history) takes in each predicted direction as soon as the prediction is made. A second register, the committed history, takes in only real outcomes, in resolution order.

Every prediction hands back the table index it used, as a checkpoint. When the branch resolves, the pipeline returns that checkpoint together with the real direction and a mispredict flag. The counter at the checkpoint index then moves toward the real outcome, and the committed history shifts. On a mispredict the speculative history is overwritten with the corrected committed history. A flag output shows whether the two histories currently differ. Resolutions must arrive in program order. The pipeline squashes younger in-flight branches on a mispredict.

Top module: `xhp_predictor`

## Requirements
- R1: The lookup index, returned on `pred_idx` in the same cycle, is `spec_hist XOR pred_pc[ADDR_LSB +: HIST_W]`. Both history registers hold the newest direction in bit 0.
- R2: `pred_taken` is bit 1 of the addressed counter. The encoding is 00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken. After reset every counter is 10 and both histories are zero.
- R3: A counter changes only on a resolve, at `res_idx`. A taken outcome adds one and saturates at 11. A not-taken outcome subtracts one and saturates at 00. Predictions never modify counters.
- R4: On every resolve the committed history shifts left by one and takes in `res_taken` as bit 0.
- R5: A prediction (`pred_valid`) with no mispredict in the same cycle shifts `pred_taken` into bit 0 of the speculative history at the next clock edge.
- R6: A resolve with `res_mispredict` high loads the speculative history with the committed history as updated by that resolve. A prediction in the same cycle is dropped.
- R7: `spec_active` is high exactly when the speculative and committed histories differ. It is updated each clock and is low after reset.
- R8: A lookup in the same cycle as a resolve to the same index returns the counter value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | A branch is being predicted this cycle |
| pred_pc | input | ADDR_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_idx | output | HIST_W | Checkpoint: table index used by this prediction |
| res_valid | input | 1 | A branch is being resolved this cycle |
| res_idx | input | HIST_W | Checkpoint returned from the prediction |
| res_taken | input | 1 | Real direction of the resolved branch |
| res_mispredict | input | 1 | The resolved branch was predicted wrongly |
| spec_active | output | 1 | Speculative history differs from committed history |

## Verification
`pred_taken` and `pred_idx` are combinational, so they are due in the same cycle as the address and are read 1 ns after inputs change on the falling edge. Counter and history effects of a cycle's stimulus become visible only through the lookup in the next cycle, and `spec_active` likewise reflects the state one edge later. The bench model therefore computes each cycle's expected outputs from its state before it applies that cycle's updates. This ordering also covers same-index read-during-write.

// File: rtl/xhp_pkg.sv
package xhp_pkg;
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_state_e;

  // Saturating step toward the real outcome (R3)
  function automatic logic [1:0] sat_step(input logic [1:0] cur, input logic up);
    if (up) return (cur == 2'b11) ? cur : cur + 2'b01;
    else    return (cur == 2'b00) ? cur : cur - 2'b01;
  endfunction
endpackage

// File: rtl/xhp_ctr_table.sv
module xhp_ctr_table
  import xhp_pkg::*;
#(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output logic [1:0]        rd_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_up
);
  localparam int DEPTH = 1 << HIST_W;

  logic [1:0] ctr_mem [DEPTH];

  // Read sees the value before any same-cycle write (R8)
  assign rd_ctr = ctr_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_mem[i] <= CTR_WEAK_T;
    end else if (wr_en) begin
      ctr_mem[wr_idx] <= sat_step(ctr_mem[wr_idx], wr_up);
    end
  end
endmodule

// File: rtl/xhp_hist_unit.sv
module xhp_hist_unit #(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_fire,
  input  logic              pred_dir,
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic              res_mispredict,
  output logic [HIST_W-1:0] spec_hist,
  output logic [HIST_W-1:0] commit_hist,
  output logic              spec_active
);
  function automatic logic [HIST_W-1:0] push_bit(input logic [HIST_W-1:0] h, input logic b);
    return {h[HIST_W-2:0], b};
  endfunction

  logic [HIST_W-1:0] commit_nx, spec_nx;
  logic              flush_evt;

  assign flush_evt = res_valid & res_mispredict;
  assign commit_nx = res_valid ? push_bit(commit_hist, res_taken) : commit_hist;

  always_comb begin
    if (flush_evt)      spec_nx = commit_nx;
    else if (pred_fire) spec_nx = push_bit(spec_hist, pred_dir);
    else                spec_nx = spec_hist;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spec_hist   <= '0;
      commit_hist <= '0;
      spec_active <= 1'b0;
    end else begin
      spec_hist   <= spec_nx;
      commit_hist <= commit_nx;
      spec_active <= (spec_nx != commit_nx);
    end
  end
endmodule

// File: rtl/xhp_predictor.sv
module xhp_predictor #(
  parameter int ADDR_W   = 32,
  parameter int HIST_W   = 12,
  parameter int ADDR_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  input  logic [ADDR_W-1:0] pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_idx,
  input  logic              res_valid,
  input  logic [HIST_W-1:0] res_idx,
  input  logic              res_taken,
  input  logic              res_mispredict,
  output logic              spec_active
);
  localparam int TOP_BIT = ADDR_LSB + HIST_W;

  function automatic logic [HIST_W-1:0] hash_idx(input logic [HIST_W-1:0] h,
                                                 input logic [ADDR_W-1:0] pc);
    return h ^ pc[ADDR_LSB +: HIST_W];
  endfunction

  logic [HIST_W-1:0] spec_hist, commit_hist;
  logic [1:0]        lookup_ctr;
  logic              pred_fire;
  logic              unused_pc_bits;

  assign unused_pc_bits = ^{pred_pc[ADDR_W-1:TOP_BIT], pred_pc[ADDR_LSB-1:0]};

  assign pred_idx   = hash_idx(spec_hist, pred_pc);   // R1
  assign pred_taken = lookup_ctr[1];                  // R2
  assign pred_fire  = pred_valid;

  xhp_ctr_table #(.HIST_W(HIST_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (pred_idx),
    .rd_ctr (lookup_ctr),
    .wr_en  (res_valid),
    .wr_idx (res_idx),
    .wr_up  (res_taken)
  );

  xhp_hist_unit #(.HIST_W(HIST_W)) u_hist (
    .clk            (clk),
    .rst_n          (rst_n),
    .pred_fire      (pred_fire),
    .pred_dir       (pred_taken),
    .res_valid      (res_valid),
    .res_taken      (res_taken),
    .res_mispredict (res_mispredict),
    .spec_hist      (spec_hist),
    .commit_hist    (commit_hist),
    .spec_active    (spec_active)
  );
endmodule

// File: rtl/xhp_checker.sv
module xhp_checker #(
  parameter int HIST_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pred_valid,
  input logic              pred_taken,
  input logic              res_valid,
  input logic              res_taken,
  input logic              res_mispredict,
  input logic [HIST_W-1:0] spec_hist,
  input logic [HIST_W-1:0] commit_hist,
  input logic              spec_active
);
  p_commit_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> commit_hist == {$past(commit_hist[HIST_W-2:0]), $past(res_taken)});

  p_commit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(commit_hist));

  p_spec_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !(res_valid && res_mispredict))
      |=> spec_hist == {$past(spec_hist[HIST_W-2:0]), $past(pred_taken)});

  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mispredict) |=> (spec_hist == commit_hist) && !spec_active);

  p_flag_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spec_active == (spec_hist != commit_hist));
endmodule

bind xhp_predictor xhp_checker #(.HIST_W(HIST_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pred_valid     (pred_valid),
  .pred_taken     (pred_taken),
  .res_valid      (res_valid),
  .res_taken      (res_taken),
  .res_mispredict (res_mispredict),
  .spec_hist      (spec_hist),
  .commit_hist    (commit_hist),
  .spec_active    (spec_active)
);

// File: tb/xhp_predictor_test.sv
`timescale 1ns/1ps
module xhp_predictor_test;
  localparam int HW = 12;
  localparam int DEPTH = 1 << HW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pred_valid = 1'b0, res_valid = 1'b0, res_taken = 1'b0, res_mispredict = 1'b0;
  logic [31:0] pred_pc = '0;
  logic [HW-1:0] res_idx = '0;
  logic pred_taken, spec_active;
  logic [HW-1:0] pred_idx;

  always #2.5 clk = ~clk;

  xhp_predictor uut (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_idx(pred_idx), .res_valid(res_valid),
    .res_idx(res_idx), .res_taken(res_taken), .res_mispredict(res_mispredict),
    .spec_active(spec_active)
  );

  int n_checks = 0, n_fail = 0;
  int m_ctr [DEPTH];
  int m_spec = 0, m_commit = 0, m_flag = 0;

  function automatic int shl(int h, int b);
    return ((h << 1) | b) & (DEPTH - 1);
  endfunction

  function automatic int bump(int c, int up);
    if (up != 0) return (c >= 3) ? 3 : c + 1;
    return (c <= 0) ? 0 : c - 1;
  endfunction

  function automatic logic [31:0] pc_for(int idx);
    return 32'((idx ^ m_spec) << 2);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: drive on falling edge, sample comb outputs 1 ns later, update model.
  task automatic cycle(string tag, bit pv, logic [31:0] pc, bit rv, int ridx,
                       bit rt, bit rm, output int got_dir, output int got_idx);
    int e_idx, e_dir, c_new;
    @(negedge clk);
    pred_valid = pv; pred_pc = pc; res_valid = rv; res_idx = HW'(ridx);
    res_taken = rt; res_mispredict = rm;
    #1;
    e_idx = (m_spec ^ int'(pc[2 +: HW]));
    e_dir = m_ctr[e_idx] >> 1;                 // R8: pre-update value
    check({tag, " R1 idx"}, int'(pred_idx), e_idx);
    check({tag, " R2 dir"}, int'(pred_taken), e_dir);
    check({tag, " R7 flag"}, int'(spec_active), m_flag);
    got_dir = int'(pred_taken); got_idx = int'(pred_idx);
    c_new = rv ? shl(m_commit, int'(rt)) : m_commit;
    if (rv) m_ctr[ridx] = bump(m_ctr[ridx], int'(rt));       // R3
    if (rv && rm) m_spec = c_new;                            // R6
    else if (pv) m_spec = shl(m_spec, e_dir);                // R5
    m_commit = c_new;                                        // R4
    m_flag = (m_spec != m_commit) ? 1 : 0;
  endtask

  task automatic idle(string tag, logic [31:0] pc);
    int d, i;
    cycle(tag, 1'b0, pc, 1'b0, 0, 1'b0, 1'b0, d, i);
  endtask

  int fifo_idx [64];
  int fifo_dir [64];

  initial begin
    int d, i, head, cnt, rv, rt, rm, pv, ridx, pdir;
    for (int k = 0; k < DEPTH; k++) m_ctr[k] = 2;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // Reset state: R2 weakly taken, R1 index equals address bits, R7 flag low
    idle("reset", 32'h0000_1234);
    check("R1 reset idx", int'(pred_idx), 12'h48D);
    check("R2 reset dir", int'(pred_taken), 1);
    check("R7 reset flag", int'(spec_active), 0);

    // R5: three taken predictions at address 0 -> speculative history 111
    cycle("R5 p0", 1, 32'h0, 0, 0, 0, 0, d, i);
    cycle("R5 p1", 1, 32'h0, 0, 0, 0, 0, d, i);
    cycle("R5 p2", 1, 32'h0, 0, 0, 0, 0, d, i);
    idle("R5 hist", 32'h0);
    check("R5 spec history", int'(pred_idx), 7);
    check("R7 flag while speculating", int'(spec_active), 1);

    // R4/R6: resolve first taken, second not taken with mispredict
    cycle("R4 res0", 0, 32'h0, 1, 0, 1, 0, d, i);
    cycle("R6 res1", 0, 32'h0, 1, 1, 0, 1, d, i);
    idle("R6 restored", 32'h0);
    check("R6 spec from commit", int'(pred_idx), 2);
    check("R7 flag after flush", int'(spec_active), 0);

    // R3: counter 1 now 01 -> predicts not taken; counter 0 now 11
    idle("R3 ctr1", pc_for(1));
    check("R3 decremented counter", int'(pred_taken), 0);
    cycle("R3 sat", 0, 32'h0, 1, 0, 1, 0, d, i);      // stays 11
    cycle("R3 dn1", 0, 32'h0, 1, 0, 0, 0, d, i);      // 10
    idle("R3 chk", pc_for(0));
    check("R3 saturated then one down", int'(pred_taken), 1);
    cycle("R3 dn2", 0, 32'h0, 1, 0, 0, 0, d, i);      // 01
    idle("R3 chk2", pc_for(0));
    check("R3 below weak", int'(pred_taken), 0);
    cycle("R3 dn3", 0, 32'h0, 1, 0, 0, 0, d, i);
    cycle("R3 dn4", 0, 32'h0, 1, 0, 0, 0, d, i);      // floors at 00
    cycle("R3 up1", 0, 32'h0, 1, 0, 1, 0, d, i);      // 01
    idle("R3 chk3", pc_for(0));
    check("R3 floor saturation", int'(pred_taken), 0);

    // R8: predict and resolve the same index in one cycle
    cycle("R8 rdw", 1, pc_for(0), 1, 0, 1, 0, d, i);
    check("R8 old value seen", d, 0);
    idle("R8 after", pc_for(0));
    check("R8 new value next", int'(pred_taken), 1);

    // Random in-order traffic with squashing on mispredict
    head = 0; cnt = 0;
    for (int n = 0; n < 4000; n++) begin
      pv = (($urandom % 3) != 0 && cnt < 60) ? 1 : 0;
      rv = (cnt > 0 && ($urandom % 2) == 0) ? 1 : 0;
      ridx = 0; pdir = 0; rt = 0; rm = 0;
      if (rv != 0) begin
        ridx = fifo_idx[head]; pdir = fifo_dir[head];
        rt = (($urandom % 4) == 0) ? 1 - pdir : pdir;
        if (($urandom % 8) == 0) rt = int'($urandom % 2);
        rm = (rt != pdir) ? 1 : 0;
        head = (head + 1) % 64; cnt--;
      end
      cycle("rand", pv[0], $urandom & 32'h0000_3FFC, rv[0], ridx, rt[0], rm[0], d, i);
      if (rm != 0) cnt = 0;
      else if (pv != 0) begin
        fifo_idx[(head + cnt) % 64] = i;
        fifo_dir[(head + cnt) % 64] = d;
        cnt++;
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule